// File: doc/BRIEF.md
# I/O Port Window Bridge

This block claims a 64 KB slice of the system physical address map and turns every access that lands in it into a transaction on a 16-bit I/O port bus. The low 16 address bits become the port number. The access size goes across unchanged, with one exception: the unused size code is turned into a word. Write data is sent on the I/O side and read data is returned on the system side. A system request that misses the window is left alone, so another decoder can answer it.

A compile-time parameter selects the byte order of the system side. With big-endian ordering, halfword data has its two bytes exchanged and word data is fully reversed, in both directions. Byte data always passes unchanged. Lanes above the access size are zero. Both sides use a simple request/acknowledge handshake, and only one transaction is in flight at a time.

Top module: `io_window_bridge`

## Requirements
- R1: A system request with address in [BASE_ADDR, BASE_ADDR + 2^WIN_BITS) (default 0x14000000 to 0x1400FFFF) is claimed. Any other address never raises io_req_o and never produces sys_ack_o.
- R2: io_port_o equals the claimed address ANDed with 0xFFFF.
- R3: io_req_o rises in the cycle after a claimed sys_req_i is sampled. It stays high, with port, size, write flag and write data stable, until io_ack_i is sampled high. It then drops at that edge.
- R4: sys_ack_o is a one-cycle pulse in the cycle after io_ack_i is sampled during a transaction. Read data appears on sys_rdata_o in that same cycle and holds until the next read completes. Writes leave sys_rdata_o unchanged.
- R5: Size code 00 (byte) moves bits [7:0] unchanged and zeroes bits [31:8], in both directions, for either byte order.
- R6: Size code 01 (halfword) zeroes bits [31:16]. Big-endian maps out[15:8]=in[7:0] and out[7:0]=in[15:8]. Little-endian passes [15:0] unchanged. This applies in both directions.
- R7: Size code 10 (word) is fully byte-reversed when big-endian (out byte k = in byte 3-k) and unchanged when little-endian, in both directions.
- R8: Size code 11 is handled exactly as a word and is forwarded on io_size_o as 10.
- R9: sys_req_i while a transaction is outstanding is ignored. io_ack_i while no transaction is outstanding is ignored.
- R10: While rst_ni is low, io_req_o and sys_ack_o are 0 and sys_rdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sys_req_i | input | 1 | System access request, sampled while idle |
| sys_we_i | input | 1 | 1 = write, 0 = read |
| sys_addr_i | input | ADDR_W | System physical address |
| sys_size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| sys_wdata_i | input | 32 | System write data |
| sys_ack_o | output | 1 | One-cycle completion pulse |
| sys_rdata_o | output | 32 | Registered read data |
| io_req_o | output | 1 | I/O request, held until acknowledged |
| io_we_o | output | 1 | I/O write flag |
| io_port_o | output | WIN_BITS | Port number |
| io_size_o | output | 2 | Normalised access size |
| io_wdata_o | output | 32 | Lane-ordered write data |
| io_ack_i | input | 1 | I/O acknowledge |
| io_rdata_i | input | 32 | I/O read data, valid with io_ack_i |

## Verification
The bench builds two copies side by side from the same stimulus. One has BIG_ENDIAN=1 and the other BIG_ENDIAN=0; both use the default base 0x14000000 and a 16-bit window. Running both orderings at once lets a single access pattern check the swapped and the pass-through lanes for every size code. Addresses just below and just above the window, and at the two window edges, check the decode boundary. Varied acknowledge delays, back-to-back requests, and stray requests or acknowledges check the handshake corners.

// File: rtl/io_bridge_pkg.sv
package io_bridge_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NBYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } io_size_e;

  typedef struct packed {
    logic                 we;
    io_size_e             size;
    logic [DATA_W-1:0]    data;
  } io_txn_t;

  // unused code folds onto word
  function automatic io_size_e norm_size(input logic [1:0] s);
    return (s == SZ_WIDE) ? SZ_WORD : io_size_e'(s);
  endfunction
endpackage

// File: rtl/io_win_decode.sv
module io_win_decode #(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        WIN_BITS  = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = 32'h1400_0000
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [WIN_BITS-1:0] port_o
);
  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:WIN_BITS];

  assign hit_o  = (addr_i[ADDR_W-1:WIN_BITS] == BASE_TAG);
  assign port_o = addr_i[WIN_BITS-1:0];

  initial begin
    AST_BASE_ALIGNED: assert (BASE_ADDR[WIN_BITS-1:0] == '0); // R1
  end
endmodule

// File: rtl/io_lane_swap.sv
module io_lane_swap
  import io_bridge_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  io_size_e          size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [NBYTES-1:0][7:0] in_b;
  logic [NBYTES-1:0][7:0] rev_b;

  assign in_b = data_i;

  for (genvar k = 0; k < NBYTES; k++) begin : g_rev
    assign rev_b[k] = in_b[NBYTES-1-k];
  end

  if (BIG_ENDIAN) begin : g_be
    always_comb begin
      unique case (size_i)
        SZ_BYTE: data_o = {24'h0, in_b[0]};
        SZ_HALF: data_o = {16'h0, in_b[0], in_b[1]};
        default: data_o = rev_b;
      endcase
    end
  end else begin : g_le
    logic [DATA_W-1:0] unused_rev;
    assign unused_rev = rev_b;
    always_comb begin
      unique case (size_i)
        SZ_BYTE: data_o = {24'h0, data_i[7:0]};
        SZ_HALF: data_o = {16'h0, data_i[15:0]};
        default: data_o = data_i;
      endcase
    end
  end
endmodule

// File: rtl/io_bridge_ctrl.sv
module io_bridge_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic io_ack_i,
  output logic launch_o,
  output logic busy_o,
  output logic done_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e state_q, state_d;
  logic done_q;

  always_comb begin
    state_d  = state_q;
    launch_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_WAIT;
        launch_o = 1'b1;
      end
      ST_WAIT: if (io_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_WAIT) && io_ack_i;
    end
  end

  assign busy_o = (state_q == ST_WAIT);
  assign done_o = done_q;

  AST_HOLD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !io_ack_i |=> busy_o); // R3
  AST_ACK_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && io_ack_i |=> done_o && !busy_o); // R4
  AST_IDLE_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !done_o); // R9
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge
  import io_bridge_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        WIN_BITS   = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR  = 32'h1400_0000,
  parameter bit                 BIG_ENDIAN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sys_req_i,
  input  logic                sys_we_i,
  input  logic [ADDR_W-1:0]   sys_addr_i,
  input  logic [1:0]          sys_size_i,
  input  logic [DATA_W-1:0]   sys_wdata_i,
  output logic                sys_ack_o,
  output logic [DATA_W-1:0]   sys_rdata_o,
  output logic                io_req_o,
  output logic                io_we_o,
  output logic [WIN_BITS-1:0] io_port_o,
  output logic [1:0]          io_size_o,
  output logic [DATA_W-1:0]   io_wdata_o,
  input  logic                io_ack_i,
  input  logic [DATA_W-1:0]   io_rdata_i
);
  logic                win_hit;
  logic [WIN_BITS-1:0] win_port;
  logic                launch, busy, done;
  io_size_e            req_size;
  logic [DATA_W-1:0]   wr_lanes, rd_lanes;
  io_txn_t             txn_q;
  logic [WIN_BITS-1:0] port_q;
  logic [DATA_W-1:0]   rdata_q;

  assign req_size = norm_size(sys_size_i);

  io_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr_i(sys_addr_i), .hit_o(win_hit), .port_o(win_port)
  );

  io_lane_swap #(.BIG_ENDIAN(BIG_ENDIAN)) u_wr_swap (
    .size_i(req_size), .data_i(sys_wdata_i), .data_o(wr_lanes)
  );

  io_lane_swap #(.BIG_ENDIAN(BIG_ENDIAN)) u_rd_swap (
    .size_i(txn_q.size), .data_i(io_rdata_i), .data_o(rd_lanes)
  );

  io_bridge_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(sys_req_i && win_hit), .io_ack_i(io_ack_i),
    .launch_o(launch), .busy_o(busy), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txn_q  <= '{we: 1'b0, size: SZ_BYTE, data: '0};
      port_q <= '0;
    end else if (launch) begin
      txn_q  <= '{we: sys_we_i, size: req_size, data: wr_lanes};
      port_q <= win_port;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rdata_q <= '0;
    else if (busy && io_ack_i && !txn_q.we) rdata_q <= rd_lanes;
  end

  assign io_req_o    = busy;
  assign io_we_o     = txn_q.we;
  assign io_port_o   = port_q;
  assign io_size_o   = txn_q.size;
  assign io_wdata_o  = txn_q.data;
  assign sys_ack_o   = done;
  assign sys_rdata_o = rdata_q;

  AST_MISS_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_req_o && sys_req_i && !win_hit |=> !io_req_o); // R1
  AST_PORT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_req_o) |-> io_port_o == $past(sys_addr_i[WIN_BITS-1:0])); // R2
  AST_FIELDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_o && !io_ack_i |=> $stable(io_port_o) && $stable(io_wdata_o) && $stable(io_size_o)); // R3
  AST_SIZE_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_o |-> io_size_o != 2'b11); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_req_o && io_ack_i) |=> $stable(sys_rdata_o)); // R4
endmodule

// File: tb/sim_io_window_bridge.sv
`timescale 1ns/1ps
module sim_io_window_bridge;
  localparam logic [31:0] BASE = 32'h1400_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sys_req = 0, sys_we = 0, io_ack = 0;
  logic [31:0] sys_addr = 0, sys_wdata = 0, io_rdata = 0;
  logic [1:0] sys_size = 0;

  logic        ack0, ack1, req0, req1, we0, we1;
  logic [31:0] rd0, rd1, wd0, wd1;
  logic [15:0] port0, port1;
  logic [1:0]  sz0, sz1;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit run_done = 0;

  always #2.5 clk = ~clk;

  io_window_bridge #(.BIG_ENDIAN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_req_i(sys_req), .sys_we_i(sys_we),
    .sys_addr_i(sys_addr), .sys_size_i(sys_size), .sys_wdata_i(sys_wdata),
    .sys_ack_o(ack0), .sys_rdata_o(rd0), .io_req_o(req0), .io_we_o(we0),
    .io_port_o(port0), .io_size_o(sz0), .io_wdata_o(wd0),
    .io_ack_i(io_ack), .io_rdata_i(io_rdata));

  io_window_bridge #(.BIG_ENDIAN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sys_req_i(sys_req), .sys_we_i(sys_we),
    .sys_addr_i(sys_addr), .sys_size_i(sys_size), .sys_wdata_i(sys_wdata),
    .sys_ack_o(ack1), .sys_rdata_o(rd1), .io_req_o(req1), .io_we_o(we1),
    .io_port_o(port1), .io_size_o(sz1), .io_wdata_o(wd1),
    .io_ack_i(io_ack), .io_rdata_i(io_rdata));

  // behavioural reference
  function automatic logic [31:0] lanes(logic [31:0] d, int n, bit be);
    logic [31:0] r = 0;
    for (int k = 0; k < n; k++)
      r[8*k +: 8] = be ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
    return r;
  endfunction
  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction
  function automatic string dtag(logic [1:0] s);
    return (s == 2'd0) ? "R5" : (s == 2'd1) ? "R6" : "R7";
  endfunction

  bit          m_busy, m_we, m_ack;
  logic [1:0]  m_size;
  logic [15:0] m_port;
  logic [31:0] m_wbe, m_wle, m_rbe, m_rle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_we <= 0; m_ack <= 0; m_size <= 0; m_port <= 0;
      m_wbe <= 0; m_wle <= 0; m_rbe <= 0; m_rle <= 0;
    end else begin
      m_ack <= 0;
      if (m_busy) begin
        if (io_ack) begin
          m_busy <= 0; m_ack <= 1;
          if (!m_we) begin
            m_rbe <= lanes(io_rdata, nbytes(m_size), 1);
            m_rle <= lanes(io_rdata, nbytes(m_size), 0);
          end
        end
      end else if (sys_req && longint'(sys_addr) >= longint'(BASE)
                   && longint'(sys_addr) < longint'(BASE) + 65536) begin
        m_busy <= 1; m_we <= sys_we;
        m_port <= 16'(sys_addr & 32'hFFFF);
        m_size <= (sys_size == 2'd3) ? 2'd2 : sys_size;
        m_wbe  <= lanes(sys_wdata, nbytes(sys_size), 1);
        m_wle  <= lanes(sys_wdata, nbytes(sys_size), 0);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rst_n && !run_done) begin
    chk("R1/R3/R9 io_req be", {31'b0, req0}, {31'b0, m_busy});
    chk("R1/R3/R9 io_req le", {31'b0, req1}, {31'b0, m_busy});
    chk("R4/R9 sys_ack be", {31'b0, ack0}, {31'b0, m_ack});
    chk("R4/R9 sys_ack le", {31'b0, ack1}, {31'b0, m_ack});
    chk({"R4 ", dtag(m_size), " rdata be"}, rd0, m_rbe);
    chk({"R4 ", dtag(m_size), " rdata le"}, rd1, m_rle);
    if (m_busy) begin
      chk("R2 port be", {16'b0, port0}, {16'b0, m_port});
      chk("R2 port le", {16'b0, port1}, {16'b0, m_port});
      chk("R8 size", {28'b0, sz0, sz1}, {28'b0, m_size, m_size});
      chk("R3 we", {30'b0, we0, we1}, {30'b0, m_we, m_we});
      if (m_we) begin
        chk({dtag(m_size), " wdata be"}, wd0, m_wbe);
        chk({dtag(m_size), " wdata le"}, wd1, m_wle);
      end
    end
  end

  task automatic access(bit we, logic [31:0] a, logic [1:0] s, logic [31:0] d,
                        logic [31:0] rsp, int dly, bit stray);
    sys_req = 1; sys_we = we; sys_addr = a; sys_size = s; sys_wdata = d;
    @(negedge clk);
    sys_req = stray;                        // R9 stray request while busy
    sys_addr = BASE + 32'h40; sys_wdata = ~d;
    for (int i = 0; i < dly; i++) begin
      @(negedge clk); sys_req = 0;
    end
    io_ack = 1; io_rdata = rsp;
    @(negedge clk);
    sys_req = 0; io_ack = 0; io_rdata = 32'hBAD0_BAD0;
  endtask

  task automatic miss(logic [31:0] a);
    sys_req = 1; sys_we = 1; sys_addr = a; sys_size = 2; sys_wdata = 32'h5555_AAAA;
    @(negedge clk);
    sys_req = 0;
    repeat (3) @(negedge clk);
    chk("R1 miss no req", {31'b0, req0 | req1}, 32'h0);
  endtask

  task automatic finish_run();
    run_done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !run_done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R3 actual=%0d expected<=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    repeat (2) @(negedge clk);
    chk("R10 reset req", {30'b0, req0, req1}, 32'h0);
    chk("R10 reset ack", {30'b0, ack0, ack1}, 32'h0);
    chk("R10 reset rdata", rd0 | rd1, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // writes, each size
    access(1, BASE + 32'h80,   2'd0, 32'hA1B2_C3D4, 0, 0, 0);
    access(1, BASE + 32'h1234, 2'd1, 32'h1122_3344, 0, 2, 0);
    access(1, BASE + 32'hFFFC, 2'd2, 32'hDEAD_BEEF, 0, 1, 1);
    access(1, BASE,            2'd3, 32'h0102_0304, 0, 0, 0);
    // reads, back to back
    access(0, BASE + 32'h60,   2'd0, 0, 32'hCAFE_F00D, 0, 0);
    access(0, BASE + 32'h3F8,  2'd1, 0, 32'h7788_99AA, 3, 1);
    access(0, BASE + 32'hFFFF, 2'd2, 0, 32'h0102_0304, 0, 0);
    chk("R7 word read be literal", rd0, 32'h0403_0201);
    chk("R7 word read le literal", rd1, 32'h0102_0304);
    access(0, BASE + 32'h10,   2'd3, 0, 32'hA0B0_C0D0, 1, 0);
    access(0, BASE + 32'h12,   2'd1, 0, 32'hFFFF_1234, 0, 0);
    chk("R6 half read be literal", rd0, 32'h0000_3412);
    // write leaves read data alone
    access(1, BASE + 32'h20,   2'd2, 32'h9999_9999, 32'h1111_1111, 0, 0);
    chk("R4 write keeps rdata", rd1, 32'h0000_1234);
    // decode boundaries
    miss(BASE - 1);
    miss(BASE + 32'h1_0000);
    miss(32'h0000_0040);
    // stray acknowledge while idle
    io_ack = 1; io_rdata = 32'hEEEE_EEEE;
    @(negedge clk);
    io_ack = 0;
    @(negedge clk);
    chk("R9 idle ack no sys_ack", {30'b0, ack0, ack1}, 32'h0);
    // mixed traffic
    for (int i = 0; i < 60; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (seed[3:0] == 4'd0) miss({seed[31:17], 1'b1, seed[15:0]} ^ 32'h8000_0000);
      else access(seed[4], BASE | {16'h0, seed[31:16]}, seed[6:5],
                  seed ^ 32'h5A5A_0F0F, {seed[15:0], seed[31:16]},
                  int'(seed[9:8]), seed[10]);
      if (seed[11]) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule